// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tags of a cache organised as a number of sets, each with a fixed number of ways. An address is split into a byte offset, a set index and a tag. A lookup compares the tag against every way of the indexed set in the same cycle. It returns hit or miss, the way that matched, and the latency in cycles that the access will take. Data storage, coherence state and the path to memory live elsewhere.

For fills, the block names a victim way in the set of the fill address. It prefers an empty way and otherwise takes the least recently used one. On insert it overwrites that way with the new tag and a time at which the line becomes ready. A runtime limit restricts victim choice to the lowest ways. Three running counters report tag-array reads, data-array reads and evictions of valid lines. The data-read count depends on whether the data array is read in parallel with the tags or only after a hit. Any stored line can be read back as a rebuilt block address.

Top module: `tag_store`

## Requirements
- R1: For an address, the set index is bits [OFFS_W+SET_W-1:OFFS_W] and the tag is the address shifted right by OFFS_W+SET_W. A lookup hits when a valid way of that set holds that tag; `hit_way_o` gives the lowest such way, in the same cycle.
- R2: `rb_addr_o` equals (stored tag << (OFFS_W+SET_W)) | (`rb_set_i` << OFFS_W) for the line at `rb_set_i`/`rb_way_i`, and `rb_valid_o` gives that line's valid bit, combinationally.
- R3: The tag-access counter rises by the current way limit on each non-probe lookup and by 1 on each insert; a probe lookup (`probe_i`=1) leaves all counters unchanged.
- R4: On a non-probe lookup the data-access counter rises by the way limit when `serial_mode_i`=0, and by 1 on a hit or 0 on a miss when `serial_mode_i`=1; an insert adds 1.
- R5: A hit reports ACC_LAT, unless the line's ready time exceeds `now_i` by more than ACC_LAT, in which case it reports (ready − now) + ACC_LAT.
- R6: A miss reports LOOK_LAT.
- R7: A non-probe hit makes the hit way most recently used in its set; a probe hit leaves recency unchanged (observed through the later victim choice).
- R8: `victim_way_o` for the set of `ins_addr_i` is the lowest invalid way below the limit if one exists, else the least recently used way below the limit. After reset, recency within a set runs from way 0 (newest) to the highest way (oldest).
- R9: An insert writes tag and ready time into the victim way, marks it valid and most recently used, and adds 1 to the eviction counter only when that way was valid.
- R10: A limit write with value 0 or above WAYS is ignored; other values take effect after the clock edge, and `alloc_lim_o` shows the limit.
- R11: After reset all lines are invalid, all counters are 0 and the limit equals WAYS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | 1: data read only after a hit; 0: data read with tags |
| now_i | input | TIME_W | Current time in cycles |
| req_i | input | 1 | Lookup request |
| probe_i | input | 1 | Lookup has no side effect |
| req_addr_i | input | ADDR_W | Lookup address |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | WAY_W | Way that hit |
| lat_o | output | TIME_W+1 | Access latency in cycles |
| ins_i | input | 1 | Insert request |
| ins_addr_i | input | ADDR_W | Address to insert |
| ins_ready_i | input | TIME_W | Ready time of the inserted line |
| victim_way_o | output | WAY_W | Way an insert would fill |
| lim_we_i | input | 1 | Write the way limit |
| lim_i | input | LIM_W | New way limit |
| alloc_lim_o | output | LIM_W | Current way limit |
| rb_set_i | input | SET_W | Read-back set |
| rb_way_i | input | WAY_W | Read-back way |
| rb_valid_o | output | 1 | Read-back line valid |
| rb_addr_o | output | ADDR_W | Rebuilt block address |
| tag_acc_o | output | CNT_W | Tag-array access count |
| data_acc_o | output | CNT_W | Data-array access count |
| repl_cnt_o | output | CNT_W | Valid-line eviction count |

## Verification
The checker assumes that a lookup and an insert never share a cycle. It also assumes that `now_i` only moves forward and stays below its wrap point, so a ready-time distance is a plain subtraction. The bench derives `now_i` from a cycle count that stays well under the wrap point. Every random step picks exactly one of lookup, insert or idle. Addresses are drawn from a few tags per set so that hits, misses, evictions and duplicate tags all occur.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ts_way_match.sv
module ts_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 25,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (eq[w]) way_o = WAY_W'(w);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/ts_lru.sv
module ts_lru #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SET_W = 3,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned LIM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] vict_set_i,
  input  logic [WAYS-1:0]  vict_valid_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic [WAY_W-1:0] victim_o
);
  // age 0 = most recent; ages of a set always form a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic             found;
    logic [WAY_W-1:0] best;
    found    = 1'b0;
    best     = '0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (w < int'(lim_i) && !vict_valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (w < int'(lim_i) && age_q[vict_set_i][w] >= best) begin
          best     = age_q[vict_set_i][w];
          victim_o = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/ts_hit_latency.sv
module ts_hit_latency #(
  parameter int unsigned TIME_W   = 16,
  parameter int unsigned LAT_W    = 17,
  parameter int unsigned ACC_LAT  = 2,
  parameter int unsigned LOOK_LAT = 1
) (
  input  logic              hit_i,
  input  logic [TIME_W-1:0] ready_i,
  input  logic [TIME_W-1:0] now_i,
  output logic [LAT_W-1:0]  lat_o
);
  logic [LAT_W-1:0] wait_c;
  logic             late;

  assign late   = ready_i > now_i;
  assign wait_c = LAT_W'(ready_i - now_i);

  always_comb begin
    if (!hit_i)                              lat_o = LAT_W'(LOOK_LAT);
    else if (late && wait_c > LAT_W'(ACC_LAT)) lat_o = wait_c + LAT_W'(ACC_LAT);
    else                                     lat_o = LAT_W'(ACC_LAT);
  end
endmodule

// File: rtl/tag_store.sv
module tag_store
  import tag_store_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SETS     = 8,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned OFFS_W   = 4,
  parameter int unsigned TIME_W   = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ACC_LAT  = 2,
  parameter int unsigned LOOK_LAT = 1,
  localparam int unsigned SET_W   = idx_w(SETS),
  localparam int unsigned WAY_W   = idx_w(WAYS),
  localparam int unsigned LIM_W   = $clog2(WAYS + 1),
  localparam int unsigned LAT_W   = TIME_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_mode_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic              req_i,
  input  logic              probe_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [LAT_W-1:0]  lat_o,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [TIME_W-1:0] ins_ready_i,
  output logic [WAY_W-1:0]  victim_way_o,
  input  logic              lim_we_i,
  input  logic [LIM_W-1:0]  lim_i,
  output logic [LIM_W-1:0]  alloc_lim_o,
  input  logic [SET_W-1:0]  rb_set_i,
  input  logic [WAY_W-1:0]  rb_way_i,
  output logic              rb_valid_o,
  output logic [ADDR_W-1:0] rb_addr_o,
  output logic [CNT_W-1:0]  tag_acc_o,
  output logic [CNT_W-1:0]  data_acc_o,
  output logic [CNT_W-1:0]  repl_cnt_o
);
  localparam int unsigned TAG_SH = OFFS_W + SET_W;
  localparam int unsigned TAG_W  = ADDR_W - TAG_SH;

  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [TIME_W-1:0] rdy_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [LIM_W-1:0]  lim_q;
  logic [CNT_W-1:0]  tag_cnt_q, data_cnt_q, repl_q;

  logic [SET_W-1:0] req_set, ins_set;
  logic [TAG_W-1:0] req_tag, ins_tag;
  assign req_set = req_addr_i[OFFS_W +: SET_W];
  assign req_tag = req_addr_i[ADDR_W-1:TAG_SH];
  assign ins_set = ins_addr_i[OFFS_W +: SET_W];
  assign ins_tag = ins_addr_i[ADDR_W-1:TAG_SH];

  logic [WAYS-1:0][TAG_W-1:0] req_tags;
  always_comb
    for (int w = 0; w < WAYS; w++) req_tags[w] = tag_q[req_set][w];

  ts_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_match (
    .tags_i (req_tags),
    .valid_i(vld_q[req_set]),
    .tag_i  (req_tag),
    .hit_o  (hit_o),
    .way_o  (hit_way_o)
  );

  ts_hit_latency #(.TIME_W(TIME_W), .LAT_W(LAT_W), .ACC_LAT(ACC_LAT),
                   .LOOK_LAT(LOOK_LAT)) i_lat (
    .hit_i  (hit_o),
    .ready_i(rdy_q[req_set][hit_way_o]),
    .now_i  (now_i),
    .lat_o  (lat_o)
  );

  logic             act_lookup, touch;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  assign act_lookup = req_i && !probe_i && !ins_i;
  assign touch      = ins_i || (act_lookup && hit_o);
  assign touch_set  = ins_i ? ins_set : req_set;
  assign touch_way  = ins_i ? victim_way_o : hit_way_o;

  ts_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
           .LIM_W(LIM_W)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (touch_set),
    .touch_way_i (touch_way),
    .vict_set_i  (ins_set),
    .vict_valid_i(vld_q[ins_set]),
    .lim_i       (lim_q),
    .victim_o    (victim_way_o)
  );

  // tag and ready arrays need no reset: valid bits guard them
  always_ff @(posedge clk_i) begin
    if (ins_i) begin
      tag_q[ins_set][victim_way_o] <= ins_tag;
      rdy_q[ins_set][victim_way_o] <= ins_ready_i;
    end
  end

  logic [CNT_W-1:0] lim_ext, tag_inc, data_inc;
  logic             lim_ok;
  assign lim_ext = CNT_W'(lim_q);
  assign lim_ok  = (lim_i != '0) && (lim_i <= LIM_W'(WAYS));

  always_comb begin
    tag_inc  = '0;
    data_inc = '0;
    if (ins_i) begin
      tag_inc  = CNT_W'(1);
      data_inc = CNT_W'(1);
    end else if (act_lookup) begin
      tag_inc  = lim_ext;
      data_inc = serial_mode_i ? CNT_W'(hit_o) : lim_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      lim_q      <= LIM_W'(WAYS);
      tag_cnt_q  <= '0;
      data_cnt_q <= '0;
      repl_q     <= '0;
    end else begin
      if (ins_i) begin
        vld_q[ins_set][victim_way_o] <= 1'b1;
        if (vld_q[ins_set][victim_way_o]) repl_q <= repl_q + 1'b1;
      end
      if (lim_we_i && lim_ok) lim_q <= lim_i;
      tag_cnt_q  <= tag_cnt_q + tag_inc;
      data_cnt_q <= data_cnt_q + data_inc;
    end
  end

  assign rb_valid_o  = vld_q[rb_set_i][rb_way_i];
  assign rb_addr_o   = (ADDR_W'(tag_q[rb_set_i][rb_way_i]) << TAG_SH)
                     | (ADDR_W'(rb_set_i) << OFFS_W);
  assign alloc_lim_o = lim_q;
  assign tag_acc_o   = tag_cnt_q;
  assign data_acc_o  = data_cnt_q;
  assign repl_cnt_o  = repl_q;
endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned WAY_W    = 2,
  parameter int unsigned LIM_W    = 3,
  parameter int unsigned LAT_W    = 17,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ACC_LAT  = 2,
  parameter int unsigned LOOK_LAT = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             serial_mode_i,
  input logic             req_i,
  input logic             probe_i,
  input logic             ins_i,
  input logic             hit_o,
  input logic [LAT_W-1:0] lat_o,
  input logic [WAY_W-1:0] victim_way_o,
  input logic             lim_we_i,
  input logic [LIM_W-1:0] lim_i,
  input logic [LIM_W-1:0] alloc_lim_o,
  input logic [CNT_W-1:0] tag_acc_o,
  input logic [CNT_W-1:0] data_acc_o,
  input logic [CNT_W-1:0] repl_cnt_o
);
  p_lim_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_lim_o != '0 && alloc_lim_o <= LIM_W'(WAYS));

  p_lim_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i && (lim_i == '0 || lim_i > LIM_W'(WAYS)) |=> $stable(alloc_lim_o));

  p_victim_below_lim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LIM_W'(victim_way_o) < alloc_lim_o);

  p_miss_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !hit_o |-> lat_o == LAT_W'(LOOK_LAT));

  p_hit_lat_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && hit_o |-> lat_o >= LAT_W'(ACC_LAT));

  p_tag_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !probe_i && !ins_i |=>
      tag_acc_o == $past(tag_acc_o) + CNT_W'($past(alloc_lim_o)));

  p_probe_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && probe_i && !ins_i |=> $stable(tag_acc_o) && $stable(data_acc_o));

  p_serial_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_mode_i && req_i && !probe_i && !ins_i && !hit_o |=> $stable(data_acc_o));

  p_ins_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> tag_acc_o == $past(tag_acc_o) + 1'b1);

  p_repl_only_ins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_i |=> $stable(repl_cnt_o));
endmodule

bind tag_store tag_store_chk #(
  .WAYS(WAYS), .WAY_W(WAY_W), .LIM_W(LIM_W), .LAT_W(LAT_W), .CNT_W(CNT_W),
  .ACC_LAT(ACC_LAT), .LOOK_LAT(LOOK_LAT)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .serial_mode_i(serial_mode_i),
  .req_i(req_i), .probe_i(probe_i), .ins_i(ins_i), .hit_o(hit_o),
  .lat_o(lat_o), .victim_way_o(victim_way_o), .lim_we_i(lim_we_i),
  .lim_i(lim_i), .alloc_lim_o(alloc_lim_o), .tag_acc_o(tag_acc_o),
  .data_acc_o(data_acc_o), .repl_cnt_o(repl_cnt_o)
);

// File: tb/test_tag_store.sv
module test_tag_store;
  localparam int NS = 8, NW = 4, OFF = 4, TSH = 7, ACC = 2, LOOK = 1;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        serial_mode_i = 1'b0;
  logic [15:0] now_i;
  logic        req_i = 0, probe_i = 0, ins_i = 0, lim_we_i = 0;
  logic [31:0] req_addr_i = '0, ins_addr_i = '0;
  logic [15:0] ins_ready_i = '0;
  logic [2:0]  lim_i = '0;
  logic [2:0]  rb_set_i = '0;
  logic [1:0]  rb_way_i = '0;
  logic        hit_o, rb_valid_o;
  logic [1:0]  hit_way_o, victim_way_o;
  logic [16:0] lat_o;
  logic [2:0]  alloc_lim_o;
  logic [31:0] rb_addr_o, tag_acc_o, data_acc_o, repl_cnt_o;

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  assign now_i = 16'(cyc);

  tag_store i_tag_store (.*);

  int checks = 0, errors = 0;
  // reference state
  int  mtag [NS][NW];
  int  mrdy [NS][NW];
  bit  mvld [NS][NW];
  int  stamp[NS][NW];
  int  gstamp = 0;
  int  lim = NW, tagc = 0, datac = 0, replc = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set);
    return 32'((tag << TSH) | (set << OFF) | 3);
  endfunction

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int ref_victim(input int s);
    int best = 0, bs = 0;
    for (int w = 0; w < lim; w++) if (!mvld[s][w]) return w;
    bs = stamp[s][0];
    for (int w = 1; w < lim; w++)
      if (stamp[s][w] < bs) begin bs = stamp[s][w]; best = w; end
    return best;
  endfunction

  task automatic step(input bit rq, input bit pb, input logic [31:0] ra,
                      input bit in_, input logic [31:0] ia, input int roff,
                      input bit lwe, input int lv, input bit ser);
    int rs, rt, is, it, hw, v, now, lat, rbs, rbw;
    bit hit;
    req_i = rq; probe_i = pb; req_addr_i = ra;
    ins_i = in_; ins_addr_i = ia; ins_ready_i = 16'(cyc + roff);
    lim_we_i = lwe; lim_i = 3'(lv); serial_mode_i = ser;
    rbs = cyc % NS; rbw = (cyc / NS) % NW;
    rb_set_i = 3'(rbs); rb_way_i = 2'(rbw);
    #1;
    now = int'(now_i);
    rs = (ra >> OFF) & (NS - 1); rt = int'(ra >> TSH);
    is = (ia >> OFF) & (NS - 1); it = int'(ia >> TSH);
    hit = 0; hw = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (mvld[rs][w] && mtag[rs][w] == rt) begin hit = 1; hw = w; end
    if (!hit) lat = LOOK;
    else if (mrdy[rs][hw] > now && mrdy[rs][hw] - now > ACC) lat = mrdy[rs][hw] - now + ACC;
    else lat = ACC;
    v = ref_victim(is);
    if (rq) begin
      check(hit_o == hit, "R1", "hit", hit_o, hit);
      if (hit) check(int'(hit_way_o) == hw, "R1", "hit way", hit_way_o, hw);
      check(int'(lat_o) == lat, hit ? "R5" : "R6", "latency", lat_o, lat);
    end
    check(int'(victim_way_o) == v, "R8", "victim", victim_way_o, v);
    check(rb_valid_o == mvld[rbs][rbw], "R2", "rb valid", rb_valid_o, mvld[rbs][rbw]);
    if (mvld[rbs][rbw])
      check(rb_addr_o == 32'((mtag[rbs][rbw] << TSH) | (rbs << OFF)), "R2", "rb addr",
            rb_addr_o, (mtag[rbs][rbw] << TSH) | (rbs << OFF));
    check(int'(tag_acc_o) == tagc, "R3", "tag count", tag_acc_o, tagc);
    check(int'(data_acc_o) == datac, "R4", "data count", data_acc_o, datac);
    check(int'(repl_cnt_o) == replc, "R9", "evictions", repl_cnt_o, replc);
    check(int'(alloc_lim_o) == lim, "R10", "limit", alloc_lim_o, lim);
    @(posedge clk_i);
    if (in_) begin
      if (mvld[is][v]) replc++;
      mtag[is][v] = it; mrdy[is][v] = now + roff; mvld[is][v] = 1;
      stamp[is][v] = ++gstamp;
      tagc++; datac++;
    end else if (rq && !pb) begin
      tagc += lim;
      datac += ser ? int'(hit) : lim;
      if (hit) stamp[rs][hw] = ++gstamp; // R7
    end
    if (lwe && lv >= 1 && lv <= NW) lim = lv;
    @(negedge clk_i);
    req_i = 0; ins_i = 0; lim_we_i = 0; probe_i = 0;
  endtask

  task automatic look(input int t, input int s, input bit pb, input bit ser);
    step(1, pb, mk(t, s), 0, '0, 0, 0, 0, ser);
  endtask
  task automatic ins(input int t, input int s, input int roff);
    step(0, 0, '0, 1, mk(t, s), roff, 0, 0, 0);
  endtask
  task automatic setlim(input int lv);
    step(0, 0, '0, 0, '0, 0, 1, lv, 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mvld[s][w] = 0; mtag[s][w] = 0; mrdy[s][w] = 0; stamp[s][w] = -w;
      end
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check(tag_acc_o == 0 && data_acc_o == 0 && repl_cnt_o == 0, "R11", "counters",
          tag_acc_o + data_acc_o + repl_cnt_o, 0);
    check(alloc_lim_o == 3'(NW), "R11", "limit", alloc_lim_o, NW);
    check(rb_valid_o == 0, "R11", "valid", rb_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8/R9: fill set 1, invalid ways taken lowest first
    for (int t = 1; t <= 4; t++) ins(t, 1, 0);
    // R1/R3/R4 parallel mode hits and a miss
    for (int t = 1; t <= 4; t++) look(t, 1, 0, 0);
    look(9, 1, 0, 0);
    // R5: line not ready yet, then a nearly ready one
    ins(5, 2, 10); look(5, 2, 0, 0);
    ins(6, 2, 2);  look(6, 2, 0, 0);
    // R7: probe LRU way 0 must not save it; real touch of way 1 does
    look(1, 1, 1, 0); look(2, 1, 0, 0);
    ins(7, 1, 0); ins(8, 1, 0);
    // R4 serial mode: hit then miss
    look(7, 1, 0, 1); look(99, 1, 0, 1);
    // R10: limit changes, rejected values
    setlim(2); ins(11, 1, 0); ins(12, 1, 0);
    setlim(0); setlim(7); look(11, 1, 0, 0);
    setlim(1); ins(13, 3, 0); ins(14, 3, 0); setlim(4);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      int t = $urandom_range(0, 6);
      int s = $urandom_range(0, NS - 1);
      bit ser = 1'($urandom_range(0, 1));
      if (op < 5) look(t, s, op == 0, ser);
      else if (op < 9) ins(t, s, $urandom_range(0, 8));
      else setlim($urandom_range(0, 6));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule